// File: doc/BRIEF.md
# BCH (15,7) Systematic Encoder

This block turns a 7-bit message into a 15-bit BCH codeword that corrects up to two bit errors. The message sits unchanged in the upper seven bits. The lower eight bits hold the remainder of m(x)·x^8 divided by the generator g(x) = x^8 + x^7 + x^6 + x^4 + 1. The message bit of weight 2^j lands at polynomial degree 8+j, so the codeword bit index equals the polynomial degree.

A parameter, chosen at build time, picks one of two variants. The word variant takes the whole message in one strobe. It forms every check bit with a fixed XOR network and registers the codeword one cycle later. The bit variant takes one message bit per accepted strobe, most significant first. It divides in an 8-bit feedback shift register and presents the codeword one cycle after the seventh accepted bit. Both variants must produce the same codeword for every message. The code length, message length and generator are parameters, and elaboration checks them.

Top module: `bch_enc`

## Requirements
- R1: While reset is asserted and after it is released, `cw_valid` is 0 and `cw_out` is all zero until the first codeword is produced.
- R2: Bits 14..8 of every codeword equal the message, with message bit 6 at codeword bit 14 and message bit 0 at codeword bit 8.
- R3: Bits 7..0 of every codeword are the remainder of the message polynomial times x^8 modulo x^8+x^7+x^6+x^4+1, so the whole 15-bit codeword is divisible by the generator.
- R4: Word variant: `cw_valid` is high in exactly the cycle after each cycle in which `in_valid` is high, and `cw_out` holds its value when `in_valid` was low.
- R5: Bit variant: message bits are taken most significant first. `cw_valid` rises for exactly one cycle, in the cycle after the seventh accepted bit.
- R6: Bit variant: a cycle with `in_valid` low is ignored whatever `in_data` carries, so gaps may appear anywhere inside a message.
- R7: Bit variant: the division state is cleared when a codeword is completed, so a message that starts in the very next cycle is encoded independently of the one before.
- R8: Both variants give identical codewords for all 128 messages.
- R9: The check bits equal the closed-form sums r0=u0^u1^u3, r1=u1^u2^u4, r2=u2^u3^u5, r3=u3^u4^u6, r4=u0^u1^u3^u4^u5, r5=u1^u2^u4^u5^u6, r6=u0^u1^u2^u5^u6, r7=u0^u2^u6, with r7 at codeword bit 7 and r0 at bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Strobe for `in_data` |
| in_data | input | 7 (word) or 1 (bit variant) | Message word, or the next message bit |
| cw_out | output | 15 | Codeword, message in the high bits |
| cw_valid | output | 1 | One-cycle flag marking a new codeword |

## Verification
The embedded properties check these points in every cycle: the one-cycle strobe latency and output hold of the word variant, the systematic placement of the message, and divisibility of each presented codeword by the generator. In the bit variant they also check the single-cycle completion pulse, the cleared state after completion, and that idle cycles leave the divider untouched. Only the bench scenarios can show that the most-significant-first bit order, back-to-back messages, random gaps with junk data and the full 128-message sweep give codewords that match an independent long division and the closed-form equations. Agreement between the two variants can likewise only be shown by running both on the same messages.

// File: rtl/bch_enc_pkg.sv
package bch_enc_pkg;

   localparam int MAXW = 32;

   // x^e reduced modulo g (degree p); result holds p low bits
   function automatic logic [MAXW-1:0] xpow_mod(input int e, input logic [MAXW-1:0] g,
                                                input int p);
      logic [MAXW-1:0] r;
      logic [MAXW-1:0] msk;
      logic            top;
      msk = (MAXW'(1) << p) - MAXW'(1);
      r   = MAXW'(1);
      for (int s = 0; s < e; s++) begin
         top = r[p-1];
         r   = (r << 1) & msk;
         if (top) r = r ^ (g & msk);
      end
      return r;
   endfunction

   // which message bits feed check bit i in the word variant
   function automatic logic [MAXW-1:0] chk_mask(input int i, input int k, input int p,
                                                input logic [MAXW-1:0] g);
      logic [MAXW-1:0] m;
      logic [MAXW-1:0] row;
      m = '0;
      for (int j = 0; j < k; j++) begin
         row  = xpow_mod(p + j, g, p);
         m[j] = row[i];
      end
      return m;
   endfunction

   // remainder of an n-bit polynomial modulo g (degree p)
   function automatic logic [MAXW-1:0] poly_rem(input logic [MAXW-1:0] v, input int n,
                                                input logic [MAXW-1:0] g, input int p);
      logic [MAXW-1:0] w;
      w = v;
      for (int b = n - 1; b >= p; b--) begin
         if (w[b]) w = w ^ (g << (b - p));
      end
      return w & ((MAXW'(1) << p) - MAXW'(1));
   endfunction

endpackage

// File: rtl/bch_par_core.sv
module bch_par_core #(
   parameter int          K   = 7,
   parameter int          N   = 15,
   parameter logic [31:0] GEN = 32'h1D1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic [K-1:0] msg,
   output logic [N-1:0] cw_out,
   output logic         cw_valid
);
   localparam int P = N - K;

   logic [P-1:0] chk;

   for (genvar gi = 0; gi < P; gi++) begin : g_chk
      localparam logic [K-1:0] TAP = K'(bch_enc_pkg::chk_mask(gi, K, P, GEN));
      assign chk[gi] = ^(msg & TAP);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cw_out   <= '0;
         cw_valid <= 1'b0;
      end else begin
         cw_valid <= in_valid;
         if (in_valid) cw_out <= {msg, chk};
      end
   end

   p_valid_follow_r4: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> cw_valid);
   p_valid_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> !cw_valid);
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> $stable(cw_out));
   p_systematic_r2: assert property (@(posedge clk) disable iff (!rst_n)
      in_valid |=> (cw_out[N-1:P] == $past(msg)));

endmodule

// File: rtl/bch_ser_core.sv
module bch_ser_core #(
   parameter int          K   = 7,
   parameter int          N   = 15,
   parameter logic [31:0] GEN = 32'h1D1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         in_valid,
   input  logic         in_bit,
   output logic [N-1:0] cw_out,
   output logic         cw_valid
);
   localparam int P  = N - K;
   localparam int MW = K - 1;
   localparam int CW = $clog2(K);
   localparam logic [P-1:0]  TAPS = P'(GEN);
   localparam logic [CW-1:0] LAST = CW'(K - 1);

   logic [P-1:0]  rem_q, rem_d;
   logic [MW-1:0] msr_q;
   logic [CW-1:0] cnt_q;
   logic          fb;

   always_comb begin
      fb    = in_bit ^ rem_q[P-1];
      rem_d = {rem_q[P-2:0], 1'b0} ^ (fb ? TAPS : '0);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rem_q    <= '0;
         msr_q    <= '0;
         cnt_q    <= '0;
         cw_out   <= '0;
         cw_valid <= 1'b0;
      end else begin
         cw_valid <= 1'b0;
         if (in_valid) begin
            if (cnt_q == LAST) begin
               cw_out   <= {msr_q, in_bit, rem_d};
               cw_valid <= 1'b1;
               rem_q    <= '0;
               msr_q    <= '0;
               cnt_q    <= '0;
            end else begin
               rem_q <= rem_d;
               msr_q <= MW'({msr_q, in_bit});
               cnt_q <= cnt_q + CW'(1);
            end
         end
      end
   end

   always @(posedge clk) begin
      if (rst_n) begin
         p_cnt_range_r5: assert (cnt_q <= LAST);
      end
   end

   p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
      cw_valid |=> !cw_valid);
   p_cleared_r7: assert property (@(posedge clk) disable iff (!rst_n)
      cw_valid |-> (cnt_q == '0 && rem_q == '0 && msr_q == '0));
   p_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
      !in_valid |=> ($stable(cnt_q) && $stable(rem_q) && $stable(msr_q) && !cw_valid));

endmodule

// File: rtl/bch_enc.sv
module bch_enc #(
   parameter int          K      = 7,
   parameter int          N      = 15,
   parameter logic [31:0] GEN    = 32'h1D1,
   parameter bit          SERIAL = 1'b0,
   localparam int         IW     = SERIAL ? 1 : K
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          in_valid,
   input  logic [IW-1:0] in_data,
   output logic [N-1:0]  cw_out,
   output logic          cw_valid
);
   localparam int P = N - K;

   if (N > 32 || K < 3 || P < 2) begin : g_bad_size
      $error("bch_enc: unsupported code size");
   end
   if (GEN[P] != 1'b1 || GEN[0] != 1'b1 || (GEN >> (P + 1)) != 32'd0) begin : g_bad_gen
      $error("bch_enc: generator degree must equal N-K with nonzero constant term");
   end

   if (SERIAL) begin : g_bit
      bch_ser_core #(.K(K), .N(N), .GEN(GEN)) u_core (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (in_valid),
         .in_bit   (in_data[0]),
         .cw_out   (cw_out),
         .cw_valid (cw_valid)
      );
   end else begin : g_word
      bch_par_core #(.K(K), .N(N), .GEN(GEN)) u_core (
         .clk      (clk),
         .rst_n    (rst_n),
         .in_valid (in_valid),
         .msg      (in_data),
         .cw_out   (cw_out),
         .cw_valid (cw_valid)
      );
   end

   p_divisible_r3: assert property (@(posedge clk) disable iff (!rst_n)
      cw_valid |-> (bch_enc_pkg::poly_rem(32'(cw_out), N, GEN, P) == 32'd0));

endmodule

// File: tb/bch_enc_tb.sv
module bch_enc_tb;
   localparam int K = 7;
   localparam int N = 15;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          p_valid = 1'b0;
   logic [K-1:0]  p_data = '0;
   logic          s_valid = 1'b0;
   logic [0:0]    s_data = '0;
   logic          s_last = 1'b0;
   logic [N-1:0]  p_cw, s_cw;
   logic          p_cv, s_cv;

   int n_cmp = 0;
   int n_bad = 0;
   logic         run_mon = 1'b0;
   logic         p_due = 1'b0, s_due = 1'b0;
   logic [K-1:0] p_q[$];
   logic [K-1:0] s_q[$];
   logic [N-1:0] p_seen[128];
   logic [N-1:0] s_seen[128];
   bit           p_has[128];
   bit           s_has[128];
   string        s_tag = "R5";

   always #10 clk = ~clk;

   bch_enc #(.K(K), .N(N), .SERIAL(1'b0)) u_dut (
      .clk(clk), .rst_n(rst_n), .in_valid(p_valid), .in_data(p_data),
      .cw_out(p_cw), .cw_valid(p_cv));

   bch_enc #(.K(K), .N(N), .SERIAL(1'b1)) u_dut_bit (
      .clk(clk), .rst_n(rst_n), .in_valid(s_valid), .in_data(s_data),
      .cw_out(s_cw), .cw_valid(s_cv));

   function automatic logic [7:0] ref_div(input logic [6:0] m);
      logic [14:0] v;
      v = {m, 8'h00};
      for (int b = 14; b >= 8; b--) if (v[b]) v = v ^ (15'h1D1 << (b - 8));
      return v[7:0];
   endfunction

   function automatic logic [7:0] ref_eq(input logic [6:0] u);
      logic [7:0] r;
      r[0] = u[0] ^ u[1] ^ u[3];
      r[1] = u[1] ^ u[2] ^ u[4];
      r[2] = u[2] ^ u[3] ^ u[5];
      r[3] = u[3] ^ u[4] ^ u[6];
      r[4] = u[0] ^ u[1] ^ u[3] ^ u[4] ^ u[5];
      r[5] = u[1] ^ u[2] ^ u[4] ^ u[5] ^ u[6];
      r[6] = u[0] ^ u[1] ^ u[2] ^ u[5] ^ u[6];
      r[7] = u[0] ^ u[2] ^ u[6];
      return r;
   endfunction

   function automatic bit divisible(input logic [14:0] c);
      logic [14:0] v;
      v = c;
      for (int b = 14; b >= 8; b--) if (v[b]) v = v ^ (15'h1D1 << (b - 8));
      return v == 15'd0;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic check_cw(input logic [N-1:0] c, input logic [K-1:0] m, input string req);
      chk(c[14:8] == m, {req, "/R2 message field"}, 32'(c[14:8]), 32'(m));
      chk(c[7:0] == ref_div(m), {req, "/R3 check bits"}, 32'(c[7:0]), 32'(ref_div(m)));
      chk(divisible(c), {req, "/R3 divisibility"}, 32'(c), 32'(m));
   endtask

   always @(posedge clk) begin
      p_due <= rst_n && p_valid;
      s_due <= rst_n && s_valid && s_last;
   end

   always @(negedge clk) begin
      if (run_mon) begin
         if (p_cv !== p_due) chk(1'b0, "R4 valid timing", 32'(p_cv), 32'(p_due));
         if (p_due) begin
            logic [K-1:0] m;
            m = p_q.pop_front();
            chk(p_cv === 1'b1, "R4 valid after strobe", 32'(p_cv), 32'd1);
            check_cw(p_cw, m, "R4");
            chk(p_cw[7:0] == ref_eq(m), "R9 closed-form check bits", 32'(p_cw[7:0]),
                32'(ref_eq(m)));
            p_seen[m] = p_cw;
            p_has[m]  = 1'b1;
         end
         if (s_cv !== s_due) chk(1'b0, {s_tag, " completion pulse"}, 32'(s_cv), 32'(s_due));
         if (s_due) begin
            logic [K-1:0] m;
            m = s_q.pop_front();
            chk(s_cv === 1'b1, {s_tag, " pulse after seventh bit"}, 32'(s_cv), 32'd1);
            check_cw(s_cw, m, s_tag);
            s_seen[m] = s_cw;
            s_has[m]  = 1'b1;
         end
      end
   end

   task automatic par_send(input logic [K-1:0] m, input int gap);
      @(negedge clk);
      p_valid = 1'b1;
      p_data  = m;
      p_q.push_back(m);
      for (int g = 0; g < gap; g++) begin
         @(negedge clk);
         p_valid = 1'b0;
         p_data  = K'($urandom);
      end
   endtask

   task automatic ser_send(input logic [K-1:0] m, input int gap_pct);
      s_q.push_back(m);
      for (int i = K - 1; i >= 0; i--) begin
         while (gap_pct > 0 && ($urandom % 100) < gap_pct) begin
            @(negedge clk);
            s_valid = 1'b0;
            s_last  = 1'b0;
            s_data  = 1'($urandom);
         end
         @(negedge clk);
         s_valid = 1'b1;
         s_data  = m[i];
         s_last  = (i == 0);
      end
   endtask

   initial begin
      void'($urandom(32'd4242));
      for (int i = 0; i < 128; i++) begin
         p_has[i] = 1'b0;
         s_has[i] = 1'b0;
      end
      repeat (3) @(negedge clk);
      chk(p_cv === 1'b0 && p_cw === '0, "R1 word variant in reset", 32'(p_cw), 32'd0);
      chk(s_cv === 1'b0 && s_cw === '0, "R1 bit variant in reset", 32'(s_cw), 32'd0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      chk(p_cv === 1'b0 && p_cw === '0, "R1 word variant after reset", 32'(p_cw), 32'd0);
      chk(s_cv === 1'b0 && s_cw === '0, "R1 bit variant after reset", 32'(s_cw), 32'd0);
      run_mon = 1'b1;

      // sweep: word strobes back to back, bit messages back to back (R7)
      fork
         begin
            for (int m = 0; m < 128; m++) par_send(K'(m), 0);
            @(negedge clk);
            p_valid = 1'b0;
         end
         begin
            s_tag = "R7";
            for (int m = 0; m < 128; m++) ser_send(K'(m), 0);
            @(negedge clk);
            s_valid = 1'b0;
            s_last  = 1'b0;
         end
      join
      repeat (3) @(negedge clk);
      // idle hold: no strobe, output must not change (R4)
      begin
         logic [N-1:0] held;
         held = p_cw;
         repeat (4) @(negedge clk);
         chk(p_cw === held, "R4 output held while idle", 32'(p_cw), 32'(held));
      end

      // random messages with gaps carrying junk data (R6), corners mixed in
      fork
         begin
            for (int n = 0; n < 150; n++) par_send(K'($urandom), int'($urandom % 3));
            par_send(7'h7F, 1);
            par_send(7'h00, 1);
            @(negedge clk);
            p_valid = 1'b0;
         end
         begin
            s_tag = "R6";
            ser_send(7'h40, 60);
            ser_send(7'h01, 60);
            for (int n = 0; n < 150; n++) ser_send(K'($urandom), 30);
            @(negedge clk);
            s_valid = 1'b0;
            s_last  = 1'b0;
         end
      join
      repeat (4) @(negedge clk);
      run_mon = 1'b0;

      chk(p_q.size() == 0, "R4 every strobe answered", 32'(p_q.size()), 32'd0);
      chk(s_q.size() == 0, "R5 every message completed", 32'(s_q.size()), 32'd0);
      chk(p_seen[0] == 15'd0 && s_seen[0] == 15'd0, "R3 zero message", 32'(s_seen[0]), 32'd0);
      chk(s_seen[1] == 15'h01D1, "R5 msb-first order, u0 only", 32'(s_seen[1]), 32'h1D1);
      for (int m = 0; m < 128; m++) begin
         chk(p_has[m] && s_has[m] && p_seen[m] == s_seen[m], "R8 variants agree",
             32'(s_seen[m]), 32'(p_seen[m]));
      end

      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule